// File: doc/BRIEF.md
# Decrementer Timer with Sign-Bit Interrupt

This block is a 32-bit down-counter for a processor's periodic interrupt. A free-running prescaler divides the input clock by four or by sixteen and emits a one-cycle tick enable. Each tick lowers the count by one. Software loads a new count through a write port and reads the live count through a read port. The block raises an interrupt request when the counter's top bit goes from 0 to 1. This happens when the count wraps from 0 to 0xFFFFFFFF, or when a written value sets that bit while it was clear. A loaded count N therefore expires after N+1 ticks.

The counter has no reset. It keeps its value across system reset and keeps counting while reset is held. System reset clears only the interrupt logic. The prescaler is cleared whenever the time-base enable is low, so the first tick after enabling always comes one full division period later. The interrupt logic is a two-state machine. `IRQ_IDLE` moves to `IRQ_PEND` on a top-bit rise (transition *raise*). `IRQ_PEND` returns to `IRQ_IDLE` on an acknowledge pulse (transition *clear*), unless a new rise arrives in the same cycle (transition *re-raise*, which stays in `IRQ_PEND`).

Top module: `dec_timer`

## Requirements
- R1: With `div_sel`=0 and `tb_en`=1, the count drops by exactly one every 4 clock cycles. The first drop comes on the 4th rising edge after `tb_en` rises.
- R2: With `div_sel`=1 and `tb_en`=1, the count drops by exactly one every 16 clock cycles. The first drop comes on the 16th rising edge after `tb_en` rises.
- R3: While `tb_en`=0 the count does not change, and the prescaler restarts from zero.
- R4: A cycle with `wr_en`=1 loads `wr_data` into the count at the next edge. If a tick falls in the same cycle, the write wins and no decrement is applied.
- R5: `rd_data` always shows the current count, and reading it does not change the count.
- R6: Holding `rst_n`=0 does not change the count, and ticks keep decrementing it during reset.
- R7: When counting wraps the count from 0x00000000 to 0xFFFFFFFF (bit 31 goes 0 to 1), `irq_pend` becomes 1 at that same edge.
- R8: A write that sets bit 31 while it was 0 raises `irq_pend`. A write that leaves bit 31 at 1, or clears it, raises nothing.
- R9: `irq_pend` stays 1 until a cycle with `irq_ack`=1, which clears it at the next edge.
- R10: If `irq_ack`=1 in the same cycle as a new bit-31 rise, `irq_pend` stays 1.
- R11: While `rst_n`=0, `irq_pend` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low system reset (clears interrupt logic only) |
| tb_en | input | 1 | Time-base enable; low stops counting and clears the prescaler |
| div_sel | input | 1 | Prescaler ratio: 0 = divide by 4, 1 = divide by 16 |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 32 | Value to load |
| rd_data | output | 32 | Live count value |
| irq_ack | input | 1 | One-cycle acknowledge that clears the pending request |
| irq_pend | output | 1 | Interrupt request pending |

## Verification
The hardest case to reach is a write that lands on exactly the edge where a tick occurs. The prescaler phase is not visible at the ports. The bench therefore first drops `tb_en` to force the prescaler to zero, then raises it and counts edges so that the write strobe sits on the fourth edge. Reaching the wrap interrupt takes the same kind of setup: the bench loads a small count while `tb_en` is low, enables counting, and samples both just before and just after the edge where the count passes zero. The acknowledge/re-raise collision is built with counting frozen. The bench first writes a value that clears bit 31, then pairs `irq_ack` with a write that sets it again.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int CNT_W       = 32;
    localparam int DIV_LO_LOG2 = 2;
    localparam int DIV_HI_LOG2 = 4;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_t;
endpackage

// File: rtl/dec_prescaler.sv
module dec_prescaler
    import dec_pkg::*;
#(
    parameter int LO_LOG2 = DIV_LO_LOG2,
    parameter int HI_LOG2 = DIV_HI_LOG2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel,
    output logic tick
);
    localparam int PW = HI_LOG2;
    localparam logic [PW-1:0] MASK_LO = PW'((1 << LO_LOG2) - 1);
    localparam logic [PW-1:0] MASK_HI = PW'((1 << HI_LOG2) - 1);

    logic [PW-1:0] phase;
    logic [PW-1:0] mask;

    always_comb begin
        mask = sel ? MASK_HI : MASK_LO;
        tick = en && ((phase & mask) == mask);
    end

    // Cleared only by a low enable, never by system reset.
    always_ff @(posedge clk) begin
        if (!en) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R3
    no_tick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase == '0));
endmodule

// File: rtl/dec_counter.sv
module dec_counter
    import dec_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         msb_rise
);
    logic [W-1:0] count_nxt;

    always_comb begin
        if (wr_en)     count_nxt = wr_data;
        else if (tick) count_nxt = count - 1'b1;
        else           count_nxt = count;
        msb_rise = !count[W-1] && count_nxt[W-1];
    end

    // No reset: the value survives system reset and counting continues.
    always_ff @(posedge clk) begin
        count <= count_nxt;
    end

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));
    // R1
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> (count == $past(count) - 1'b1));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(count));
endmodule

// File: rtl/dec_irq_fsm.sv
module dec_irq_fsm
    import dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic ack,
    output logic pend
);
    irq_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            IRQ_IDLE: if (rise) state_nxt = IRQ_PEND;          // raise
            IRQ_PEND: if (ack && !rise) state_nxt = IRQ_IDLE;  // clear / re-raise
            default:  state_nxt = IRQ_IDLE;
        endcase
    end

    always_comb begin
        pend = (state == IRQ_PEND);
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);
    // R10
    reraise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend);
endmodule

// File: rtl/dec_timer.sv
module dec_timer
    import dec_pkg::*;
#(
    parameter int W       = CNT_W,
    parameter int LO_LOG2 = DIV_LO_LOG2,
    parameter int HI_LOG2 = DIV_HI_LOG2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tb_en,
    input  logic         div_sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         irq_ack,
    output logic         irq_pend
);
    logic tick;
    logic msb_rise;

    dec_prescaler #(.LO_LOG2(LO_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tb_en),
        .sel  (div_sel),
        .tick (tick)
    );

    dec_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .count   (rd_data),
        .msb_rise(msb_rise)
    );

    dec_irq_fsm u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .rise (msb_rise),
        .ack  (irq_ack),
        .pend (irq_pend)
    );

    // R7
    msb_edge_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[W-1] ##1 rd_data[W-1] |-> irq_pend);
    // R11
    reset_pend_chk: assert property (@(posedge clk)
        !rst_n |-> !irq_pend);
endmodule

// File: tb/sim_dec_timer.sv
module sim_dec_timer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        tb_en = 0;
    logic        div_sel = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_ack = 0;
    logic        irq_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dec_timer u0 (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .div_sel(div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_ack(irq_ack), .irq_pend(irq_pend)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Load with counting stopped; leaves the prescaler cleared.
    task automatic load_frozen(logic [31:0] v);
        tb_en = 0; wr_en = 1; wr_data = v;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
    endtask

    task automatic ack_pulse();
        irq_ack = 1; @(negedge clk); irq_ack = 0;
    endtask

    task automatic t_reset_state();
        edges(2);
        chk("R11 pend in reset", {31'b0, irq_pend}, 32'd0);
        load_frozen(32'h0000_0100);
        chk("R4 load in reset", rd_data, 32'h0000_0100);
        tb_en = 1;
        edges(8);
        chk("R6 counts during reset", rd_data, 32'h0000_00FE);
        tb_en = 0;
        edges(1);
        rst_n = 1;
        edges(1);
        chk("R6 reset release keeps count", rd_data, 32'h0000_00FE);
    endtask

    task automatic t_div4();
        load_frozen(32'h0000_1000);
        tb_en = 1; div_sel = 0;
        edges(3);
        chk("R1 before first tick", rd_data, 32'h0000_1000);
        edges(1);
        chk("R1 first tick", rd_data, 32'h0000_0FFF);
        edges(40);
        chk("R1 eleven ticks", rd_data, 32'h0000_0FF5);
        chk("R5 read has no effect", rd_data, 32'h0000_0FF5);
        tb_en = 0;
        edges(20);
        chk("R3 frozen when disabled", rd_data, 32'h0000_0FF5);
    endtask

    task automatic t_div16();
        load_frozen(32'h0000_0040);
        tb_en = 1; div_sel = 1;
        edges(15);
        chk("R2 before first tick", rd_data, 32'h0000_0040);
        edges(1);
        chk("R2 first tick", rd_data, 32'h0000_003F);
        edges(32);
        chk("R2 three ticks", rd_data, 32'h0000_003D);
        tb_en = 0; div_sel = 0;
        edges(1);
    endtask

    task automatic t_write_priority();
        load_frozen(32'h0000_0500);
        tb_en = 1;
        edges(3);
        wr_en = 1; wr_data = 32'h0000_0ABC;
        @(negedge clk);
        wr_en = 0;
        chk("R4 write beats tick", rd_data, 32'h0000_0ABC);
        edges(4);
        chk("R1 tick after write", rd_data, 32'h0000_0ABB);
        tb_en = 0;
        edges(1);
    endtask

    task automatic t_wrap();
        if (irq_pend) ack_pulse();
        load_frozen(32'h0000_0001);
        chk("R8 small write no pend", {31'b0, irq_pend}, 32'd0);
        tb_en = 1;
        edges(7);
        chk("R7 at zero", rd_data, 32'h0000_0000);
        chk("R7 no pend at zero", {31'b0, irq_pend}, 32'd0);
        edges(1);
        chk("R7 wrapped", rd_data, 32'hFFFF_FFFF);
        chk("R7 pend on wrap", {31'b0, irq_pend}, 32'd1);
        tb_en = 0;
        edges(10);
        chk("R9 pend held", {31'b0, irq_pend}, 32'd1);
        ack_pulse();
        chk("R9 ack clears", {31'b0, irq_pend}, 32'd0);
    endtask

    task automatic t_write_edges();
        load_frozen(32'h9000_0000);
        chk("R8 write 1->1 no pend", {31'b0, irq_pend}, 32'd0);
        load_frozen(32'h1234_5678);
        chk("R8 write clears msb no pend", {31'b0, irq_pend}, 32'd0);
        load_frozen(32'h8000_0000);
        chk("R8 write sets msb pend", {31'b0, irq_pend}, 32'd1);
        load_frozen(32'h0000_0005);
        chk("R9 still pending", {31'b0, irq_pend}, 32'd1);
        irq_ack = 1; wr_en = 1; wr_data = 32'hC000_0000;
        @(negedge clk);
        irq_ack = 0; wr_en = 0;
        chk("R10 ack with new edge keeps pend", {31'b0, irq_pend}, 32'd1);
        ack_pulse();
        chk("R9 later ack clears", {31'b0, irq_pend}, 32'd0);
        rst_n = 0;
        edges(2);
        chk("R6 reset keeps count", rd_data, 32'hC000_0000);
        rst_n = 1;
        edges(1);
    endtask

    initial begin
        t_reset_state();
        t_div4();
        t_div16();
        t_write_priority();
        t_wrap();
        t_write_edges();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule